// File: doc/BRIEF.md
# Timer Capture/Compare Channel Bank

This block holds three identical capture/compare channels that sit beside a free-running counter and its precounter. Each channel is configured through a small register port and operates in one of three states. When off it ignores its inputs. In capture it watches one of twelve synchronous event inputs and copies the main counter into its value register whenever the chosen edge condition occurs. In compare it tests its value register for equality against either the main counter or a combined word. That word is the low 17 counter bits placed above the 15 precounter bits. A programmable number of the most significant bits is left out of the test.

Every capture or compare hit is an event. An event sets the channel's sticky flag on the same clock edge. It also updates the channel's output pin according to a chosen action: a one-cycle pulse, a toggle, a forced low or a forced high. A compare hit counts only on the cycle in which equality starts. A counter that rests on the matching value therefore fires once.

Each channel is a small state machine with the states `ST_OFF`, `ST_CAPTURE` and `ST_COMPARE`. Any configuration write to a channel moves it, from whatever state it is in, to the state named by the mode field of the written word. Mode 0 and mode 3 lead to `ST_OFF`, mode 1 to `ST_CAPTURE` and mode 2 to `ST_COMPARE`. No other transition exists.

Top module: `cc_channel_bank`

## Requirements
- R1: After reset, every channel is in `ST_OFF` with value 0, output low and flag low.
- R2: In `ST_OFF`, event inputs and counter values cause no flag, no output change other than a pulse output staying low, and no change of the value register.
- R3: Configuration word layout is: bits [1:0] mode (0 off, 1 capture, 2 compare, 3 off); bits [3:2] action (0 pulse, 1 toggle, 2 clear, 3 set); bits [7:4] event select; bits [9:8] edge (0 rising, 1 falling, 2 both, 3 level); bit 10 compare base (0 main counter, 1 combined); bits [15:11] mask count. In capture, edge 0 hits when the selected input is 1 and was 0 on the previous cycle, edge 1 hits on the opposite change, and edge 2 hits on either change.
- R4: With edge 3, capture hits on every cycle in which the selected input is 1, with no edge detection.
- R5: Event selects 0 to 11 pick that event input. Selects 12 to 15 pick nothing and never cause a capture.
- R6: In compare with base 0, an event occurs on a cycle where the main counter equals the value register and did not on the previous cycle, or the channel was not in compare on that cycle. Holding on the matching value gives no further event.
- R7: With base 1, the compared word is counter bits [16:0] above precounter bits [14:0]. Counter bits above 16 have no effect.
- R8: A mask count N removes the N most significant bits of the 32-bit compare from the equality test.
- R9: On an event, the output goes high for exactly one cycle (pulse), inverts (toggle), goes low (clear) or goes high (set). Without an event, a pulse output is low and the other actions hold the output.
- R10: An event sets the channel flag at the clock edge on which it is detected. The flag stays set until a clear request, and a new event in the same cycle as a clear leaves the flag set.
- R11: A value-register write lands at the next edge and takes priority over a capture in the same cycle. Channels do not affect one another.
- R12: An all-zero configuration field set gives rising-edge capture from event input 0, and pulse output with no masking in compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt | input | 32 | Main counter value |
| precnt | input | 15 | Precounter value |
| evt_in | input | 12 | Event inputs, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 2 | Channel addressed by the write |
| wr_is_value | input | 1 | 1 writes the value register, 0 writes the configuration word |
| wr_data | input | 32 | Write data |
| rd_ch | input | 2 | Channel whose value register is shown on rd_value |
| rd_value | output | 32 | Value register of channel rd_ch (0 for an absent channel) |
| flag_clr | input | 3 | Per-channel flag clear requests |
| ch_out | output | 3 | Per-channel output pins |
| ch_flag | output | 3 | Per-channel sticky interrupt flags |

## Verification
The hardest case to reach is a compare hit that must not repeat. The counter has to enter the matching value, rest there while the flag is cleared, then leave and return. This shows that resting is silent and re-entry is not. The bench drives the counter inputs directly, so it can hold, step back and revisit a value at will. It also lines up a value write with a level-mode capture in the same cycle, and a flag clear with a new event. A behavioural model then tracks all three channels on every clock.

// File: rtl/cc_pkg.sv
package cc_pkg;

    localparam int EVT_SEL_W = 4;
    localparam int MASK_W    = 5;

    typedef enum logic [1:0] {
        ACT_PULSE  = 2'd0,
        ACT_TOGGLE = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_SET    = 2'd3
    } cc_act_e;

    typedef enum logic [1:0] {
        EDGE_RISE  = 2'd0,
        EDGE_FALL  = 2'd1,
        EDGE_BOTH  = 2'd2,
        EDGE_LEVEL = 2'd3
    } cc_edge_e;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_COMPARE = 2'd2
    } cc_state_e;

    // Configuration word, bits [15:0], most significant field first.
    typedef struct packed {
        logic [MASK_W-1:0]    mask;
        logic                 base_comb;
        cc_edge_e             edge_sel;
        logic [EVT_SEL_W-1:0] evt_sel;
        cc_act_e              action;
        logic [1:0]           mode;
    } cc_cfg_t;

    function automatic cc_state_e mode_to_state(input logic [1:0] m);
        case (m)
            2'd1:    return ST_CAPTURE;
            2'd2:    return ST_COMPARE;
            default: return ST_OFF;
        endcase
    endfunction

endpackage

// File: rtl/cc_edge_sense.sv
module cc_edge_sense
    import cc_pkg::*;
(
    input  logic     cur,
    input  logic     prev,
    input  cc_edge_e edge_sel,
    output logic     hit
);

    always_comb begin
        unique case (edge_sel)
            EDGE_RISE:  hit = cur & ~prev;
            EDGE_FALL:  hit = ~cur & prev;
            EDGE_BOTH:  hit = cur ^ prev;
            EDGE_LEVEL: hit = cur;
        endcase
    end

endmodule

// File: rtl/cc_cmp_unit.sv
module cc_cmp_unit #(
    parameter int W      = 32,
    parameter int PRE_W  = 15,
    parameter int MASK_W = 5
) (
    input  logic [W-1:0]      cnt,
    input  logic [PRE_W-1:0]  precnt,
    input  logic              base_comb,
    input  logic [MASK_W-1:0] mask,
    input  logic [W-1:0]      value,
    output logic              eq
);

    localparam int LOW_W = W - PRE_W;

    logic [W-1:0] base_word;
    logic [W-1:0] keep_bits;

    generate
        if (PRE_W > 0 && LOW_W > 0) begin : g_comb
            assign base_word = base_comb ? {cnt[LOW_W-1:0], precnt} : cnt;
        end else begin : g_plain
            assign base_word = cnt;
        end
    endgenerate

    assign keep_bits = {W{1'b1}} >> mask;
    assign eq        = ((base_word ^ value) & keep_bits) == '0;

endmodule

// File: rtl/cc_channel.sv
module cc_channel
    import cc_pkg::*;
#(
    parameter int W       = 32,
    parameter int PRE_W   = 15,
    parameter int NUM_EVT = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [W-1:0]       cnt,
    input  logic [PRE_W-1:0]   precnt,
    input  logic [NUM_EVT-1:0] evt_cur,
    input  logic [NUM_EVT-1:0] evt_prev,
    input  logic               cfg_we,
    input  logic               val_we,
    input  logic [W-1:0]       wr_data,
    input  logic               flag_clr,
    output logic [W-1:0]       value,
    output logic               out,
    output logic               flag
);

    localparam int PAD_W = 1 << EVT_SEL_W;

    cc_state_e         state_q;
    cc_cfg_t           cfg_q;
    logic [W-1:0]      value_q;
    logic              out_q;
    logic              flag_q;
    logic              eqp_q;

    logic [PAD_W-1:0]  cur_pad;
    logic [PAD_W-1:0]  prev_pad;
    logic              sel_cur;
    logic              sel_prev;
    logic              edge_hit;
    logic              eq;
    logic              ev;
    logic              eqp_d;
    logic              out_d;

    assign cur_pad  = PAD_W'(evt_cur);
    assign prev_pad = PAD_W'(evt_prev);
    assign sel_cur  = cur_pad[cfg_q.evt_sel];
    assign sel_prev = prev_pad[cfg_q.evt_sel];

    cc_edge_sense u_edge (
        .cur      (sel_cur),
        .prev     (sel_prev),
        .edge_sel (cfg_q.edge_sel),
        .hit      (edge_hit)
    );

    cc_cmp_unit #(
        .W      (W),
        .PRE_W  (PRE_W),
        .MASK_W (MASK_W)
    ) u_cmp (
        .cnt       (cnt),
        .precnt    (precnt),
        .base_comb (cfg_q.base_comb),
        .mask      (cfg_q.mask),
        .value     (value_q),
        .eq        (eq)
    );

    // State register: every configuration write selects the next state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else if (cfg_we) begin
            state_q <= mode_to_state(wr_data[1:0]);
        end
    end

    // Event and output decisions per state.
    always_comb begin
        ev    = 1'b0;
        eqp_d = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                ev    = 1'b0;
                eqp_d = 1'b0;
            end
            ST_CAPTURE: begin
                ev    = edge_hit;
                eqp_d = 1'b0;
            end
            ST_COMPARE: begin
                ev    = eq & ~eqp_q;
                eqp_d = eq;
            end
            default: begin
                ev    = 1'b0;
                eqp_d = 1'b0;
            end
        endcase

        if (ev) begin
            unique case (cfg_q.action)
                ACT_PULSE:  out_d = 1'b1;
                ACT_TOGGLE: out_d = ~out_q;
                ACT_CLEAR:  out_d = 1'b0;
                ACT_SET:    out_d = 1'b1;
            endcase
        end else if (cfg_q.action == ACT_PULSE) begin
            out_d = 1'b0;
        end else begin
            out_d = out_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            value_q <= '0;
            out_q   <= 1'b0;
            flag_q  <= 1'b0;
            eqp_q   <= 1'b0;
        end else begin
            if (cfg_we) begin
                cfg_q <= cc_cfg_t'(wr_data[15:0]);
            end
            if (val_we) begin
                value_q <= wr_data;
            end else if (ev && state_q == ST_CAPTURE) begin
                value_q <= cnt;
            end
            out_q  <= out_d;
            eqp_q  <= eqp_d;
            if (ev) begin
                flag_q <= 1'b1;
            end else if (flag_clr) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign value = value_q;
    assign out   = out_q;
    assign flag  = flag_q;

    // R10: an event is visible on the flag after the edge that saw it.
    a_r10_flag_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> flag_q);

    // R11: a value write always lands, capture or not.
    a_r11_value_write: assert property (@(posedge clk) disable iff (!rst_n)
        val_we |=> (value_q == $past(wr_data)));

    // R9: in pulse action the output mirrors the previous cycle's event.
    a_r9_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.action == ACT_PULSE) |=> (out_q == $past(ev)));

    // R2: an off channel keeps its value unless written.
    a_r2_off_holds_value: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && !val_we) |=> $stable(value_q));

    // R6: a compare hit cannot repeat on the very next cycle.
    a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMPARE && ev && !cfg_we) |=> !ev);

endmodule

// File: rtl/cc_channel_bank.sv
module cc_channel_bank
    import cc_pkg::*;
#(
    parameter int NUM_CH  = 3,
    parameter int NUM_EVT = 12,
    parameter int CNT_W   = 32,
    parameter int PRE_W   = 15,
    parameter int CH_W    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   cnt,
    input  logic [PRE_W-1:0]   precnt,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               wr_en,
    input  logic [CH_W-1:0]    wr_ch,
    input  logic               wr_is_value,
    input  logic [CNT_W-1:0]   wr_data,
    input  logic [CH_W-1:0]    rd_ch,
    output logic [CNT_W-1:0]   rd_value,
    input  logic [NUM_CH-1:0]  flag_clr,
    output logic [NUM_CH-1:0]  ch_out,
    output logic [NUM_CH-1:0]  ch_flag
);

    logic [NUM_EVT-1:0] evt_q;
    logic [CNT_W-1:0]   val_arr [NUM_CH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= evt_in;
        end
    end

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            logic sel_me;
            assign sel_me = wr_en && (wr_ch == CH_W'(i));

            cc_channel #(
                .W       (CNT_W),
                .PRE_W   (PRE_W),
                .NUM_EVT (NUM_EVT)
            ) u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .cnt      (cnt),
                .precnt   (precnt),
                .evt_cur  (evt_in),
                .evt_prev (evt_q),
                .cfg_we   (sel_me && !wr_is_value),
                .val_we   (sel_me && wr_is_value),
                .wr_data  (wr_data),
                .flag_clr (flag_clr[i]),
                .value    (val_arr[i]),
                .out      (ch_out[i]),
                .flag     (ch_flag[i])
            );
        end
    endgenerate

    always_comb begin
        rd_value = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (rd_ch == CH_W'(k)) begin
                rd_value = val_arr[k];
            end
        end
    end

    // R1: the bank leaves reset quiet.
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (ch_flag == '0 && ch_out == '0));

endmodule

// File: tb/tb_cc_channel_bank.sv
module tb_cc_channel_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cnt = '0;
    logic [14:0] precnt = '0;
    logic [11:0] evt_in = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_ch = '0;
    logic        wr_is_value = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_ch = '0;
    logic [31:0] rd_value;
    logic [2:0]  flag_clr = '0;
    logic [2:0]  ch_out;
    logic [2:0]  ch_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_req = "R1";

    // Behavioural model state
    logic [31:0] m_cfg [3];
    logic [31:0] m_val [3];
    logic        m_out [3];
    logic        m_flag [3];
    logic        m_eqp [3];
    logic [11:0] m_evq;

    always #5 clk = ~clk;

    cc_channel_bank dut (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .precnt(precnt), .evt_in(evt_in),
        .wr_en(wr_en), .wr_ch(wr_ch), .wr_is_value(wr_is_value), .wr_data(wr_data),
        .rd_ch(rd_ch), .rd_value(rd_value), .flag_clr(flag_clr),
        .ch_out(ch_out), .ch_flag(ch_flag)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 3; c++) begin
            m_cfg[c] = '0; m_val[c] = '0; m_out[c] = 0; m_flag[c] = 0; m_eqp[c] = 0;
        end
        m_evq = '0;
    endtask

    task automatic model_step();
        logic [31:0] nv [3];
        logic        no [3];
        logic        nf [3];
        logic        ne [3];
        logic [31:0] nc [3];
        for (int c = 0; c < 3; c++) begin
            int mode = int'(m_cfg[c][1:0]);
            int act  = int'(m_cfg[c][3:2]);
            int sel  = int'(m_cfg[c][7:4]);
            int edg  = int'(m_cfg[c][9:8]);
            int msk  = int'(m_cfg[c][15:11]);
            bit s = (sel < 12) ? evt_in[sel] : 1'b0;
            bit p = (sel < 12) ? m_evq[sel] : 1'b0;
            bit ev = 0;
            bit eq;
            logic [31:0] base = m_cfg[c][10] ? {cnt[16:0], precnt} : cnt;
            eq = (((base ^ m_val[c]) << msk) == 32'd0);
            ne[c] = 0;
            if (mode == 1) begin
                case (edg)
                    0: ev = s && !p;
                    1: ev = !s && p;
                    2: ev = s != p;
                    default: ev = s;
                endcase
            end else if (mode == 2) begin
                ev = eq && !m_eqp[c];
                ne[c] = eq;
            end
            nv[c] = m_val[c];
            if (wr_en && wr_is_value && wr_ch == c) nv[c] = wr_data;
            else if (ev && mode == 1) nv[c] = cnt;
            nc[c] = m_cfg[c];
            if (wr_en && !wr_is_value && wr_ch == c) nc[c] = {16'd0, wr_data[15:0]};
            no[c] = m_out[c];
            if (ev) no[c] = (act == 1) ? !m_out[c] : (act != 2);
            else if (act == 0) no[c] = 0;
            nf[c] = ev ? 1'b1 : (flag_clr[c] ? 1'b0 : m_flag[c]);
        end
        for (int c = 0; c < 3; c++) begin
            m_val[c] = nv[c]; m_out[c] = no[c]; m_flag[c] = nf[c];
            m_eqp[c] = ne[c]; m_cfg[c] = nc[c];
        end
        m_evq = evt_in;
    endtask

    task automatic compare_model();
        logic [2:0] eo = {m_out[2], m_out[1], m_out[0]};
        logic [2:0] ef = {m_flag[2], m_flag[1], m_flag[0]};
        chk(ch_out == eo && ch_flag == ef, {cur_req, " outputs/flags"},
            {26'd0, ch_flag, ch_out}, {26'd0, ef, eo});
        chk(rd_value == m_val[rd_ch], {cur_req, " value"}, rd_value, m_val[rd_ch]);
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_model();
        wr_en = 0; flag_clr = '0;
    endtask

    task automatic wcfg(input int ch, input logic [31:0] d);
        wr_en = 1; wr_is_value = 0; wr_ch = 2'(ch); wr_data = d;
        tick();
    endtask

    task automatic wval(input int ch, input logic [31:0] d);
        wr_en = 1; wr_is_value = 1; wr_ch = 2'(ch); wr_data = d;
        tick();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R1";
        chk(ch_out == 0 && ch_flag == 0, "R1 reset outputs", {29'd0, ch_out}, 0);
        chk(rd_value == 0, "R1 reset value", rd_value, 0);
        tick();

        // R12 default capture: rising, event 0, pulse
        cur_req = "R12";
        wcfg(0, 32'h1);
        rd_ch = 0; cnt = 32'h1234; evt_in[0] = 1;
        tick();
        chk(rd_value == 32'h1234, "R12 capture value", rd_value, 32'h1234);
        chk(ch_flag[0] && ch_out[0], "R12 flag and pulse", {30'd0, ch_flag[0], ch_out[0]}, 3);
        cnt = 32'h2000;
        tick();
        chk(ch_out[0] == 0, "R9 pulse one cycle", {31'd0, ch_out[0]}, 0);
        chk(rd_value == 32'h1234, "R3 no capture on held high", rd_value, 32'h1234);
        cur_req = "R10";
        flag_clr[0] = 1;
        tick();
        chk(ch_flag[0] == 0, "R10 flag clear", {31'd0, ch_flag[0]}, 0);

        // R3 falling / both on ch1, event 3, toggle
        cur_req = "R3";
        wcfg(1, 32'h135);
        rd_ch = 1; evt_in[3] = 1; cnt = 32'h44;
        tick();
        chk(rd_value == 0, "R3 falling ignores rise", rd_value, 0);
        evt_in[3] = 0; cnt = 32'h55;
        tick();
        chk(rd_value == 32'h55 && ch_out[1], "R3 falling capture", rd_value, 32'h55);
        wcfg(1, 32'h235);
        evt_in[3] = 1; cnt = 32'h66;
        tick();
        chk(rd_value == 32'h66 && !ch_out[1], "R3 both edges capture", rd_value, 32'h66);

        // R4 level
        cur_req = "R4";
        wcfg(1, 32'h335);
        for (int k = 0; k < 3; k++) begin
            cnt = 32'h70 + k;
            tick();
        end
        chk(rd_value == 32'h72 && ch_out[1], "R4 level captures each cycle", rd_value, 32'h72);
        evt_in[3] = 0; cnt = 32'h80;
        tick();
        chk(rd_value == 32'h72, "R4 level low no capture", rd_value, 32'h72);

        // R5 event select
        cur_req = "R5";
        wcfg(1, 32'h3D1);
        flag_clr[1] = 1; evt_in = 12'hFFF; cnt = 32'h90;
        tick();
        tick();
        chk(rd_value == 32'h72 && !ch_flag[1], "R5 select 13 never captures", rd_value, 32'h72);
        wcfg(1, 32'h3B1);
        evt_in = 12'h800; cnt = 32'h91;
        tick();
        chk(rd_value == 32'h91, "R5 select 11 captures", rd_value, 32'h91);

        // R2 off
        cur_req = "R2";
        wcfg(0, 32'h0);
        rd_ch = 0; flag_clr = 3'b001;
        for (int k = 0; k < 4; k++) begin
            evt_in[0] = k[0]; cnt = 32'h300 + k;
            tick();
        end
        chk(!ch_flag[0] && rd_value == 32'h1234, "R2 off ignores events", rd_value, 32'h1234);

        // R6 compare main counter, set action
        cur_req = "R6";
        evt_in = '0; rd_ch = 2; cnt = 32'd95;
        wval(2, 32'd100);
        wcfg(2, 32'hE);
        for (int k = 96; k <= 100; k++) begin
            cnt = k;
            tick();
        end
        chk(ch_flag[2] && ch_out[2], "R6 match sets flag and output", {30'd0, ch_flag[2], ch_out[2]}, 3);
        flag_clr[2] = 1;
        tick();
        tick(); tick();
        chk(!ch_flag[2], "R6 held match no retrigger", {31'd0, ch_flag[2]}, 0);
        cnt = 32'd101; tick();
        cnt = 32'd100; tick();
        chk(ch_flag[2], "R6 re-entry matches", {31'd0, ch_flag[2]}, 1);

        // R7 combined base, toggle
        cur_req = "R7";
        flag_clr[2] = 1;
        wcfg(2, 32'h406);
        wval(2, 32'h28010);
        cnt = 32'hABC00005; precnt = 15'h0F;
        tick();
        chk(!ch_flag[2], "R7 no match below", {31'd0, ch_flag[2]}, 0);
        precnt = 15'h10;
        tick();
        chk(ch_flag[2] && !ch_out[2], "R7 combined match toggles", {30'd0, ch_flag[2], ch_out[2]}, 2);

        // R8 mask, pulse
        cur_req = "R8";
        precnt = '0; flag_clr[2] = 1;
        wcfg(2, 32'hE002);
        wval(2, 32'hF0000007);
        cnt = 32'd6; tick();
        cnt = 32'd7; tick();
        chk(ch_flag[2] && ch_out[2], "R8 masked match", {30'd0, ch_flag[2], ch_out[2]}, 3);
        flag_clr[2] = 1;
        wcfg(2, 32'h0002);
        cnt = 32'd6; tick();
        cnt = 32'd7; tick();
        chk(!ch_flag[2], "R8 unmasked no match", {31'd0, ch_flag[2]}, 0);

        // R9 set and clear actions
        cur_req = "R9";
        wcfg(2, 32'hE);
        wval(2, 32'h10);
        cnt = 32'hF; tick();
        cnt = 32'h10; tick();
        chk(ch_out[2] == 1, "R9 set action", {31'd0, ch_out[2]}, 1);
        wcfg(2, 32'hA);
        cnt = 32'h11; tick();
        cnt = 32'h10; tick();
        chk(ch_out[2] == 0, "R9 clear action", {31'd0, ch_out[2]}, 0);

        // R11 write over capture; R10 event beats clear
        cur_req = "R11";
        rd_ch = 1;
        wcfg(1, 32'h3B1);
        evt_in = 12'h800; cnt = 32'h500;
        wval(1, 32'hBEEF);
        chk(rd_value == 32'hBEEF, "R11 write wins over capture", rd_value, 32'hBEEF);
        cnt = 32'h501; flag_clr[1] = 1;
        tick();
        chk(rd_value == 32'h501 && ch_flag[1], "R10 event beats clear", rd_value, 32'h501);
        chk(ch_out[2] == 0 && !ch_flag[0], "R11 channels independent", {29'd0, ch_out}, {29'd0, ch_out[2:1], 1'b0});

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule